// File: doc/BRIEF.md
# Strobed Handshake Port Controller

This block is a single 8-bit data port that moves bytes between a host and a peripheral through a latch and a two-wire handshake. A direction input picks the transfer direction. In input direction the peripheral pulls its active-low strobe to capture a byte in the latch. A buffer-full flag then tells the peripheral to wait, and once the strobe is released an interrupt request asks the host to read the byte. In output direction a host write fills the latch and pulls an active-low buffer-full line. The peripheral answers with an active-low acknowledge. When the acknowledge is released, the interrupt request tells the host that the next byte may be written.

All four strobes (peripheral strobe, acknowledge, host read and host write) are asynchronous to the block clock. Each is brought through a synchroniser, and the block acts on edges of the synchronised copies. The host sees three locations: the data latch, a status byte, and a command location. The command location sets or clears the interrupt enable one bit at a time. The host read data is a combinational function of the host address.

Top module: `strobe_port`

## Requirements
- R1: After reset the buffer-full flag `ibf` is 0, `obf_n` is 1, the interrupt enable is 0, `irq` is 0, `per_dout` is 0 and the status byte reads 0x00 in input direction.
- R2: In input direction (`dir_out`=0), a falling edge of `per_stb_n` captures `per_din` into the input latch and sets `ibf`. The host reads the latch at address 0.
- R3: In input direction, asserting `host_rd_n` at address 0 clears `irq`, and releasing it clears `ibf`.
- R4: In input direction, `irq` rises only while `per_stb_n` is high, `ibf` is 1 and the interrupt enable is 1. It stays low while the strobe is held low.
- R5: In output direction (`dir_out`=1), releasing `host_wr_n` at address 0 loads `host_wdata` into `per_dout` and drives `obf_n` low. In input direction a data-port write leaves `per_dout` unchanged.
- R6: In output direction, a falling edge of `per_ack_n` returns `obf_n` to 1.
- R7: In output direction, `irq` rises while `per_ack_n` is high, `obf_n` is 1 and the interrupt enable is 1. Asserting `host_wr_n` at address 0 clears it.
- R8: A write to address 2 with bit 7 = 0 and bits 3:1 equal to 4 copies bit 0 into the interrupt enable. Any other command byte leaves the enable unchanged.
- R9: While the interrupt enable is 0, `irq` is 0 from the next cycle on.
- R10: Address 1 reads the status byte: bit 0 is the buffer flag (`ibf` in input direction, `obf_n` in output direction), bit 1 is the interrupt enable, bit 2 is `irq`, and bits 7:3 are 0.
- R11: A change of `dir_out` clears `ibf` and `irq` and sets `obf_n` to 1. The latches and the interrupt enable keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_out | input | 1 | 1 = output direction, 0 = input direction |
| host_addr | input | 2 | 0 data, 1 status, 2 command |
| host_wdata | input | 8 | Host write data |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_rdata | output | 8 | Host read data for the addressed location |
| per_din | input | 8 | Byte from the peripheral |
| per_dout | output | 8 | Output latch towards the peripheral |
| per_stb_n | input | 1 | Peripheral strobe, active low |
| per_ack_n | input | 1 | Peripheral acknowledge, active low |
| ibf | output | 1 | Input buffer full |
| obf_n | output | 1 | Output buffer full, active low |
| irq | output | 1 | Interrupt request to the host |

## Verification
The hardest case to reach from the ports is the window between the host asserting its read strobe and releasing it. In that window the interrupt must already be low while `ibf` is still high. A similar window exists during an output write, where the interrupt must fall before `obf_n` does. The stimulus holds each strobe low for several cycles, longer than the synchroniser delay, and samples the outputs in the middle of that hold. It then samples again after the release. This separates the two edges that clear the flags. Other directed steps cover an enable cleared while a request is pending, command bytes with the wrong bit index or the mode bit set, and a direction change while the buffer is full.

// File: rtl/strobe_port.sv
module strobe_port #(
  parameter int W      = 8,
  parameter int SYNC   = 2,
  parameter int IE_IDX = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_out,
  input  logic [1:0]   host_addr,
  input  logic [W-1:0] host_wdata,
  input  logic         host_rd_n,
  input  logic         host_wr_n,
  output logic [W-1:0] host_rdata,
  input  logic [W-1:0] per_din,
  output logic [W-1:0] per_dout,
  input  logic         per_stb_n,
  input  logic         per_ack_n,
  output logic         ibf,
  output logic         obf_n,
  output logic         irq
);
  localparam int NS = 4;
  localparam int IW = $clog2(W) > 3 ? $clog2(W) : 3;

  logic [NS-1:0] raw, pipe [SYNC], prev, now;
  assign raw = {host_rd_n, host_wr_n, per_ack_n, per_stb_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pipe[0] <= '1;
    else        pipe[0] <= raw;

  for (genvar i = 1; i < SYNC; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pipe[i] <= '1;
      else        pipe[i] <= pipe[i-1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= '1;
    else        prev <= now;

  assign now = pipe[SYNC-1];

  logic stb_s, ack_s, wr_s, rd_s;
  logic stb_fall, ack_fall, wr_rise, wr_fall, rd_rise, rd_fall;
  assign {rd_s, wr_s, ack_s, stb_s} = now;
  assign stb_fall = prev[0] & ~stb_s;
  assign ack_fall = prev[1] & ~ack_s;
  assign wr_rise  = ~prev[2] & wr_s;
  assign wr_fall  = prev[2] & ~wr_s;
  assign rd_rise  = ~prev[3] & rd_s;
  assign rd_fall  = prev[3] & ~rd_s;

  logic a_data, a_cmd;
  assign a_data = host_addr == 2'd0;
  assign a_cmd  = host_addr == 2'd2;

  logic wr_rise_dat, wr_fall_dat, rd_rise_dat, rd_fall_dat;
  assign wr_rise_dat = wr_rise & a_data;
  assign wr_fall_dat = wr_fall & a_data;
  assign rd_rise_dat = rd_rise & a_data;
  assign rd_fall_dat = rd_fall & a_data;

  logic cmd_hit;
  assign cmd_hit = wr_rise & a_cmd & ~host_wdata[W-1]
                 & (host_wdata[IW:1] == IW'(IE_IDX));

  logic         ie, dir_q;
  logic [W-1:0] in_lat, out_lat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ie <= 1'b0;
    else if (cmd_hit) ie <= host_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      ibf     <= 1'b0;
      obf_n   <= 1'b1;
      irq     <= 1'b0;
      in_lat  <= '0;
      out_lat <= '0;
    end else begin
      dir_q <= dir_out;
      if (dir_q != dir_out) begin
        ibf   <= 1'b0;
        obf_n <= 1'b1;
        irq   <= 1'b0;
      end else if (!dir_out) begin
        if (stb_fall) begin
          in_lat <= per_din;
          ibf    <= 1'b1;
        end else if (rd_rise_dat) ibf <= 1'b0;
        if (!ie || rd_fall_dat) irq <= 1'b0;
        else if (stb_s && ibf && rd_s && !rd_rise_dat) irq <= 1'b1;
      end else begin
        if (wr_rise_dat) begin
          out_lat <= host_wdata;
          obf_n   <= 1'b0;
        end else if (ack_fall) obf_n <= 1'b1;
        if (!ie || wr_fall_dat) irq <= 1'b0;
        else if (ack_s && obf_n && wr_s && !wr_rise_dat) irq <= 1'b1;
      end
    end
  end

  assign per_dout = out_lat;

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      2'd0:    host_rdata = in_lat;
      2'd1:    host_rdata = W'({irq, ie, dir_out ? obf_n : ibf});
      default: host_rdata = '0;
    endcase
  end
endmodule

module strobe_port_chk (
  input logic clk,
  input logic rst_n,
  input logic dir_out,
  input logic ibf,
  input logic obf_n,
  input logic irq,
  input logic ie,
  input logic stb_fall,
  input logic ack_fall,
  input logic wr_rise_dat,
  input logic rd_fall_dat
);
  // R2
  ibf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibf) |-> $past(stb_fall) && !dir_out);
  // R5
  obf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(obf_n) |-> $past(wr_rise_dat) && dir_out);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |=> !irq);
  // R3
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall_dat && !dir_out) |=> !irq);
  // R6
  ack_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && !wr_rise_dat) |=> obf_n);
endmodule

bind strobe_port strobe_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .ibf(ibf), .obf_n(obf_n),
  .irq(irq), .ie(ie), .stb_fall(stb_fall), .ack_fall(ack_fall),
  .wr_rise_dat(wr_rise_dat), .rd_fall_dat(rd_fall_dat)
);

// File: tb/sim_strobe_port.sv
module sim_strobe_port;
  logic       clk = 1'b0, rst_n = 1'b0, dir_out = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = '0, per_din = '0;
  logic       host_rd_n = 1'b1, host_wr_n = 1'b1, per_stb_n = 1'b1, per_ack_n = 1'b1;
  logic [7:0] host_rdata, per_dout;
  logic       ibf, obf_n, irq;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  strobe_port u0 (
    .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .host_rdata(host_rdata), .per_din(per_din), .per_dout(per_dout),
    .per_stb_n(per_stb_n), .per_ack_n(per_ack_n), .ibf(ibf), .obf_n(obf_n),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic status(input string req, input logic [7:0] exp);
    host_addr = 2'd1;
    #1 chk(req, host_rdata, exp);
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr_n = 1'b0; step(6);
    host_wr_n = 1'b1; step(6);
  endtask

  task automatic t_reset;
    chk("R1 ibf", ibf, 0); chk("R1 obf_n", obf_n, 1);
    chk("R1 irq", irq, 0); chk("R1 dout", per_dout, 0);
    status("R1 status", 8'h00);
  endtask

  task automatic t_in_plain;
    per_din = 8'h5A; per_stb_n = 1'b0; step(6);
    chk("R2 ibf set", ibf, 1); chk("R4 irq low while strobe low", irq, 0);
    per_stb_n = 1'b1; per_din = 8'h00; step(6);
    chk("R9 irq off without enable", irq, 0);
    host_addr = 2'd0; host_rd_n = 1'b0; step(6);
    chk("R2 latch", host_rdata, 8'h5A); chk("R3 ibf held during read", ibf, 1);
    host_rd_n = 1'b1; step(6);
    chk("R3 ibf cleared", ibf, 0);
  endtask

  task automatic t_cmd_set;
    hwrite(2'd2, 8'h09);
    status("R8 enable set", 8'h02);
  endtask

  task automatic t_in_irq;
    per_din = 8'hA5; per_stb_n = 1'b0; step(6);
    chk("R4 no irq while strobe low", irq, 0);
    per_stb_n = 1'b1; step(6);
    chk("R4 irq after strobe release", irq, 1);
    status("R10 status full", 8'h07);
    host_addr = 2'd0; host_rd_n = 1'b0; step(6);
    chk("R3 irq cleared on read", irq, 0); chk("R3 ibf still set", ibf, 1);
    chk("R2 latch", host_rdata, 8'hA5);
    host_rd_n = 1'b1; step(6);
    chk("R3 ibf cleared", ibf, 0); chk("R3 irq stays low", irq, 0);
  endtask

  task automatic t_cmd_ignore;
    hwrite(2'd2, 8'h08);
    status("R8 enable cleared", 8'h00);
    hwrite(2'd2, 8'h0B);
    status("R8 wrong index ignored", 8'h00);
    hwrite(2'd2, 8'h89);
    status("R8 mode bit ignored", 8'h00);
    hwrite(2'd2, 8'h09);
    status("R8 enable set again", 8'h02);
  endtask

  task automatic t_ie_off;
    per_din = 8'h3C; per_stb_n = 1'b0; step(6);
    per_stb_n = 1'b1; step(6);
    chk("R4 irq pending", irq, 1);
    hwrite(2'd2, 8'h08);
    chk("R9 irq dropped", irq, 0);
    status("R10 status ibf only", 8'h01);
    hwrite(2'd0, 8'h77);
    chk("R5 write ignored in input", per_dout, 8'h00);
    dir_out = 1'b1; step(6);
    chk("R11 ibf cleared", ibf, 0); chk("R11 obf_n", obf_n, 1);
    status("R10 status output idle", 8'h01);
  endtask

  task automatic t_out;
    hwrite(2'd2, 8'h09);
    chk("R7 irq ready", irq, 1);
    host_addr = 2'd0; host_wdata = 8'hC3; host_wr_n = 1'b0; step(6);
    chk("R7 irq cleared by write", irq, 0); chk("R5 obf_n before release", obf_n, 1);
    host_wr_n = 1'b1; step(6);
    chk("R5 obf_n low", obf_n, 0); chk("R5 dout", per_dout, 8'hC3);
    chk("R7 irq low while full", irq, 0);
    per_ack_n = 1'b0; step(6);
    chk("R6 obf_n returned", obf_n, 1); chk("R7 irq low while ack low", irq, 0);
    per_ack_n = 1'b1; step(6);
    chk("R7 irq after ack release", irq, 1);
    status("R10 status output", 8'h07);
    dir_out = 1'b0; step(6);
    chk("R11 irq cleared", irq, 0);
    host_addr = 2'd0;
    #1 chk("R11 input latch kept", host_rdata, 8'h3C);
    status("R11 enable kept", 8'h02);
  endtask

  initial begin
    step(3); rst_n = 1'b1; step(3);
    t_reset;
    t_in_plain;
    t_cmd_set;
    t_in_irq;
    t_cmd_ignore;
    t_ie_off;
    t_out;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule